// File: doc/BRIEF.md
# Debug Mode Entry/Exit Controller

This block holds the debug-mode state of a single hart together with its four debug CSRs: a control/status word, the saved return PC and two scratch words. Each cycle it looks at four possible reasons to stop the hart: a halt request from the external debug module, a trigger hit whose action asks for debug mode, an ebreak reaching retirement, and the end of a single step. When one or more of them is present and the hart is not already halted, the block enters debug mode. It records the winning reason and the PC of the instruction that did not complete. It also saves the privilege the hart was running at, and it points fetch at a fixed debug ROM address.

While the hart is in debug mode, the debug ROM or the program buffer reaches the CSRs through a simple access port. When the debug-return instruction retires, the block sends fetch back to the saved PC and hands back the saved privilege. It also acknowledges the resume and leaves debug mode. An ebreak whose privilege has its routing bit clear is passed on as an ordinary breakpoint trap.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: After reset the hart is not in debug mode: `debug_mode_o`, `halted_o`, `resume_ack_o`, `redirect_o` and `ebreak_trap_o` are all 0.
- R2: A halt request seen outside debug mode makes `debug_mode_o` and `halted_o` go to 1 on the next cycle. On that same cycle a one-cycle `redirect_o` pulse carries `ROM_BASE` and `priv_o`=3. The saved PC takes `pc_i`, the cause field takes 3, and the prior-privilege field takes `priv_i`.
- R3: A trigger hit outside debug mode enters debug mode in the same way as R2, but with cause 2 and the saved PC equal to `pc_i` of the hit cycle.
- R4: An ebreak is routed into debug mode with cause 1 when the control/status routing bit for `priv_i` is set: bit 15 for machine (3), bit 14 for supervisor (1), bit 13 for user (0). Otherwise `ebreak_trap_o` is 1 in that same cycle and debug mode is not entered.
- R5: Entry reasons that arrive together are ranked trigger (2) first, then ebreak (1), then halt request (3), then step (4). The recorded cause is the highest-ranked reason present.
- R6: When the step bit (bit 2) is set as the hart leaves debug mode, the hart runs freely until one `retire_i` pulse. One cycle later, with no further input, it enters debug mode with cause 4 and the saved PC equal to `pc_i` of that cycle.
- R7: While in debug mode, halt requests, trigger hits, ebreaks and retirements do not change the cause, the saved PC or the mode, and produce no redirect and no `ebreak_trap_o`.
- R8: When `dret_i` retires in debug mode, on the next cycle `debug_mode_o` is 0, `resume_ack_o` pulses, and `redirect_o` carries the saved PC with `priv_o` equal to the prior-privilege field. `halted_o` falls one cycle after the acknowledge.
- R9: The control/status word (CSR 0x7B0) reads version 4 in bits 31:28 and the cause in bits 8:6; both are read-only. The routing bits 15:13, the step bit 2 and the prior privilege in bits 1:0 are writable. All other bits read 0.
- R10: The control/status word, the saved PC (0x7B1) and the scratch words (0x7B2, 0x7B3) can be read and written only in debug mode. An access outside debug mode raises `csr_err_o`, returns 0 and leaves the register unchanged.
- R11: A value written to the saved PC in debug mode is the one used as the return address by the next `dret_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_req_i | input | 1 | Halt request from the external debug module |
| trig_hit_i | input | 1 | Trigger hit whose action requests debug mode |
| ebreak_i | input | 1 | Ebreak at `pc_i` is reaching retirement |
| retire_i | input | 1 | An instruction retired this cycle |
| dret_i | input | 1 | Debug-return instruction retired |
| pc_i | input | XLEN | PC of the oldest instruction that has not completed |
| priv_i | input | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| csr_en_i | input | 1 | CSR access strobe |
| csr_we_i | input | 1 | CSR access is a write |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | XLEN | CSR write data |
| csr_rdata_o | output | XLEN | CSR read data (combinational) |
| csr_err_o | output | 1 | Illegal CSR access |
| ebreak_trap_o | output | 1 | Ebreak must take the ordinary breakpoint trap |
| debug_mode_o | output | 1 | Hart is in debug mode |
| halted_o | output | 1 | Halted status toward the debug module |
| resume_ack_o | output | 1 | Resume acknowledge pulse |
| redirect_o | output | 1 | Fetch redirect pulse |
| redirect_pc_o | output | XLEN | Redirect target |
| priv_o | output | 2 | Privilege to take with the redirect |

## Verification
Two things can meet in the same cycle: competing entry reasons, and a step that is just completing. The bench raises trigger, ebreak and halt request together. It also raises ebreak and halt request together, and it drives a halt request in the very cycle a pending step would cause entry. In each case it reads the cause field back and expects the higher-ranked code, with the saved PC from that cycle. Every fetch redirect is matched in order against a queue of expected target, privilege and direction.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  typedef enum logic [2:0] {
    CAUSE_NONE    = 3'd0,
    CAUSE_EBREAK  = 3'd1,
    CAUSE_TRIGGER = 3'd2,
    CAUSE_HALTREQ = 3'd3,
    CAUSE_STEP    = 3'd4
  } dbg_cause_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [3:0] DBG_VERSION = 4'd4;

  localparam logic [11:0] CSR_CTRL = 12'h7B0;
  localparam logic [11:0] CSR_RPC  = 12'h7B1;
  localparam logic [11:0] CSR_SCR0 = 12'h7B2;
  localparam logic [11:0] CSR_SCR1 = 12'h7B3;

  localparam int EN_M_BIT  = 15;
  localparam int EN_S_BIT  = 14;
  localparam int EN_U_BIT  = 13;
  localparam int STEP_BIT  = 2;
endpackage

// File: rtl/dbg_entry_arb.sv
module dbg_entry_arb
  import dbg_pkg::*;
(
  input  logic       in_debug,
  input  logic       trig_hit,
  input  logic       ebreak,
  input  logic       halt_req,
  input  logic       step_evt,
  input  logic [1:0] priv,
  input  logic [2:0] route_en,   // {machine, supervisor, user}
  output logic       enter,
  output logic [2:0] cause,
  output logic       ebreak_trap
);
  logic       eb_route;
  dbg_cause_e win;

  always_comb begin
    case (priv)
      PRIV_M:  eb_route = route_en[2];
      PRIV_S:  eb_route = route_en[1];
      PRIV_U:  eb_route = route_en[0];
      default: eb_route = 1'b0;
    endcase
  end

  // fixed ranking: trigger, ebreak, halt request, step
  always_comb begin
    win = CAUSE_NONE;
    if (!in_debug) begin
      if (trig_hit)               win = CAUSE_TRIGGER;
      else if (ebreak && eb_route) win = CAUSE_EBREAK;
      else if (halt_req)          win = CAUSE_HALTREQ;
      else if (step_evt)          win = CAUSE_STEP;
    end
  end

  assign enter       = (win != CAUSE_NONE);
  assign cause       = win;
  assign ebreak_trap = ebreak && !in_debug && !trig_hit && !eb_route;
endmodule

// File: rtl/dbg_step_seq.sv
module dbg_step_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic in_debug,
  input  logic exit_now,
  input  logic step_bit,
  input  logic retire,
  input  logic enter_now,
  output logic step_evt
);
  logic armed_q, armed_d;
  logic pend_q, pend_d;

  always_comb begin
    armed_d = armed_q;
    pend_d  = 1'b0;
    if (exit_now) begin
      armed_d = step_bit;
    end else if (enter_now) begin
      armed_d = 1'b0;
    end else if (armed_q && !in_debug && retire) begin
      armed_d = 1'b0;
      pend_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      pend_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pend_q  <= pend_d;
    end
  end

  assign step_evt = pend_q;
endmodule

// File: rtl/dbg_csr_regs.sv
module dbg_csr_regs
  import dbg_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_debug,
  input  logic            enter,
  input  logic [2:0]      enter_cause,
  input  logic [XLEN-1:0] enter_pc,
  input  logic [1:0]      enter_priv,
  input  logic            csr_en,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_err,
  output logic [2:0]      route_en,
  output logic            step_bit,
  output logic [1:0]      prv,
  output logic [XLEN-1:0] rpc
);
  localparam int CTRL_W = 32;
  localparam int PAD_W  = (XLEN > CTRL_W) ? XLEN - CTRL_W : 0;

  logic [2:0]      route_q, route_d;
  logic            step_q, step_d;
  logic [1:0]      prv_q, prv_d;
  logic [2:0]      cause_q, cause_d;
  logic [XLEN-1:0] rpc_q, rpc_d;
  logic [XLEN-1:0] scr0_q, scr0_d;
  logic [XLEN-1:0] scr1_q, scr1_d;

  logic            hit;
  logic            wr_ok;
  logic [CTRL_W-1:0] ctrl_word;

  always_comb begin
    case (csr_addr)
      CSR_CTRL, CSR_RPC, CSR_SCR0, CSR_SCR1: hit = 1'b1;
      default:                               hit = 1'b0;
    endcase
  end

  assign csr_err = csr_en && (!in_debug || !hit);
  assign wr_ok   = csr_en && csr_we && in_debug && hit;

  assign ctrl_word = {DBG_VERSION, 12'd0, route_q, 4'd0, cause_q, 3'd0, step_q, prv_q};

  always_comb begin
    csr_rdata = '0;
    if (csr_en && in_debug) begin
      case (csr_addr)
        CSR_CTRL: begin
          if (PAD_W > 0) csr_rdata = XLEN'(ctrl_word);
          else           csr_rdata = ctrl_word[XLEN-1:0];
        end
        CSR_RPC:  csr_rdata = rpc_q;
        CSR_SCR0: csr_rdata = scr0_q;
        CSR_SCR1: csr_rdata = scr1_q;
        default:  csr_rdata = '0;
      endcase
    end
  end

  always_comb begin
    route_d = route_q;
    step_d  = step_q;
    prv_d   = prv_q;
    cause_d = cause_q;
    rpc_d   = rpc_q;
    scr0_d  = scr0_q;
    scr1_d  = scr1_q;
    if (enter) begin
      cause_d = enter_cause;
      rpc_d   = enter_pc;
      prv_d   = enter_priv;
    end else if (wr_ok) begin
      case (csr_addr)
        CSR_CTRL: begin
          route_d = {csr_wdata[EN_M_BIT], csr_wdata[EN_S_BIT], csr_wdata[EN_U_BIT]};
          step_d  = csr_wdata[STEP_BIT];
          prv_d   = csr_wdata[1:0];
        end
        CSR_RPC:  rpc_d  = csr_wdata;
        CSR_SCR0: scr0_d = csr_wdata;
        CSR_SCR1: scr1_d = csr_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      route_q <= '0;
      step_q  <= 1'b0;
      prv_q   <= PRIV_M;
      cause_q <= '0;
      rpc_q   <= '0;
      scr0_q  <= '0;
      scr1_q  <= '0;
    end else begin
      route_q <= route_d;
      step_q  <= step_d;
      prv_q   <= prv_d;
      cause_q <= cause_d;
      rpc_q   <= rpc_d;
      scr0_q  <= scr0_d;
      scr1_q  <= scr1_d;
    end
  end

  assign route_en = route_q;
  assign step_bit = step_q;
  assign prv      = prv_q;
  assign rpc      = rpc_q;
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbg_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] ROM_BASE = 'h800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halt_req_i,
  input  logic            trig_hit_i,
  input  logic            ebreak_i,
  input  logic            retire_i,
  input  logic            dret_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [1:0]      priv_i,
  input  logic            csr_en_i,
  input  logic            csr_we_i,
  input  logic [11:0]     csr_addr_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            csr_err_o,
  output logic            ebreak_trap_o,
  output logic            debug_mode_o,
  output logic            halted_o,
  output logic            resume_ack_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic [1:0]      priv_o
);
  logic            dbg_q, dbg_d;
  logic            halted_q, halted_d;
  logic            ack_q, ack_d;
  logic            redir_q, redir_d;
  logic [XLEN-1:0] rpc_out_q, rpc_out_d;
  logic [1:0]      priv_q, priv_d;

  logic            enter;
  logic [2:0]      cause;
  logic            step_evt;
  logic            exit_now;
  logic [2:0]      route_en;
  logic            step_bit;
  logic [1:0]      prv;
  logic [XLEN-1:0] rpc;

  assign exit_now = dbg_q && dret_i;

  dbg_entry_arb u_arb (
    .in_debug    (dbg_q),
    .trig_hit    (trig_hit_i),
    .ebreak      (ebreak_i),
    .halt_req    (halt_req_i),
    .step_evt    (step_evt),
    .priv        (priv_i),
    .route_en    (route_en),
    .enter       (enter),
    .cause       (cause),
    .ebreak_trap (ebreak_trap_o)
  );

  dbg_step_seq u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_debug  (dbg_q),
    .exit_now  (exit_now),
    .step_bit  (step_bit),
    .retire    (retire_i),
    .enter_now (enter),
    .step_evt  (step_evt)
  );

  dbg_csr_regs #(.XLEN(XLEN)) u_csr (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_debug    (dbg_q),
    .enter       (enter),
    .enter_cause (cause),
    .enter_pc    (pc_i),
    .enter_priv  (priv_i),
    .csr_en      (csr_en_i),
    .csr_we      (csr_we_i),
    .csr_addr    (csr_addr_i),
    .csr_wdata   (csr_wdata_i),
    .csr_rdata   (csr_rdata_o),
    .csr_err     (csr_err_o),
    .route_en    (route_en),
    .step_bit    (step_bit),
    .prv         (prv),
    .rpc         (rpc)
  );

  always_comb begin
    dbg_d     = dbg_q;
    halted_d  = halted_q;
    ack_d     = exit_now;
    redir_d   = enter || exit_now;
    rpc_out_d = rpc_out_q;
    priv_d    = priv_q;
    if (ack_q) halted_d = 1'b0;
    if (enter) begin
      dbg_d     = 1'b1;
      halted_d  = 1'b1;
      rpc_out_d = ROM_BASE;
      priv_d    = PRIV_M;
    end else if (exit_now) begin
      dbg_d     = 1'b0;
      rpc_out_d = rpc;
      priv_d    = prv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q     <= 1'b0;
      halted_q  <= 1'b0;
      ack_q     <= 1'b0;
      redir_q   <= 1'b0;
      rpc_out_q <= '0;
      priv_q    <= PRIV_M;
    end else begin
      dbg_q     <= dbg_d;
      halted_q  <= halted_d;
      ack_q     <= ack_d;
      redir_q   <= redir_d;
      rpc_out_q <= rpc_out_d;
      priv_q    <= priv_d;
    end
  end

  assign debug_mode_o  = dbg_q;
  assign halted_o      = halted_q;
  assign resume_ack_o  = ack_q;
  assign redirect_o    = redir_q;
  assign redirect_pc_o = rpc_out_q;
  assign priv_o        = priv_q;
endmodule

// File: rtl/dbg_mode_ctrl_chk.sv
module dbg_mode_ctrl_chk #(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] ROM_BASE = 'h800
) (
  input logic            clk,
  input logic            rst_n,
  input logic            halt_req_i,
  input logic            dret_i,
  input logic            csr_en_i,
  input logic            csr_err_o,
  input logic            ebreak_trap_o,
  input logic            debug_mode_o,
  input logic            halted_o,
  input logic            resume_ack_o,
  input logic            redirect_o,
  input logic [XLEN-1:0] redirect_pc_o
);
  // R2
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!debug_mode_o && halt_req_i) |=> (debug_mode_o && redirect_o && redirect_pc_o == ROM_BASE));

  // R4
  no_trap_in_debug_chk: assert property (@(posedge clk) disable iff (!rst_n)
    debug_mode_o |-> !ebreak_trap_o);

  // R7
  quiet_in_debug_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (debug_mode_o && !dret_i) |=> !redirect_o);

  // R8
  dret_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (debug_mode_o && dret_i) |=> (!debug_mode_o && resume_ack_o && redirect_o));

  // R8
  ack_after_dret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_ack_o |-> $past(debug_mode_o && dret_i));

  // R8
  halted_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted_o) |-> $past(resume_ack_o));

  // R10
  csr_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_en_i && !debug_mode_o) |-> csr_err_o);
endmodule

bind dbg_mode_ctrl dbg_mode_ctrl_chk #(.XLEN(XLEN), .ROM_BASE(ROM_BASE)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .halt_req_i    (halt_req_i),
  .dret_i        (dret_i),
  .csr_en_i      (csr_en_i),
  .csr_err_o     (csr_err_o),
  .ebreak_trap_o (ebreak_trap_o),
  .debug_mode_o  (debug_mode_o),
  .halted_o      (halted_o),
  .resume_ack_o  (resume_ack_o),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o)
);

// File: tb/tb_dbg_mode_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_mode_ctrl;
  localparam int          XLEN = 32;
  localparam logic [31:0] ROM  = 32'h800;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            halt_req_i, trig_hit_i, ebreak_i, retire_i, dret_i;
  logic [XLEN-1:0] pc_i;
  logic [1:0]      priv_i;
  logic            csr_en_i, csr_we_i;
  logic [11:0]     csr_addr_i;
  logic [XLEN-1:0] csr_wdata_i;
  logic [XLEN-1:0] csr_rdata_o;
  logic            csr_err_o, ebreak_trap_o, debug_mode_o, halted_o, resume_ack_o, redirect_o;
  logic [XLEN-1:0] redirect_pc_o;
  logic [1:0]      priv_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [31:0] q_pc[$];
  logic [1:0]  q_prv[$];
  logic        q_dm[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  dbg_mode_ctrl #(.XLEN(XLEN), .ROM_BASE(ROM)) dut (
    .clk(clk), .rst_n(rst_n), .halt_req_i(halt_req_i), .trig_hit_i(trig_hit_i),
    .ebreak_i(ebreak_i), .retire_i(retire_i), .dret_i(dret_i), .pc_i(pc_i),
    .priv_i(priv_i), .csr_en_i(csr_en_i), .csr_we_i(csr_we_i), .csr_addr_i(csr_addr_i),
    .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o), .csr_err_o(csr_err_o),
    .ebreak_trap_o(ebreak_trap_o), .debug_mode_o(debug_mode_o), .halted_o(halted_o),
    .resume_ack_o(resume_ack_o), .redirect_o(redirect_o), .redirect_pc_o(redirect_pc_o),
    .priv_o(priv_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_redirect(input string req, input logic [31:0] pc,
                                 input logic [1:0] prv, input logic dm);
    q_pc.push_back(pc); q_prv.push_back(prv); q_dm.push_back(dm); q_tag.push_back(req);
  endtask

  // monitor: every redirect must match the oldest expected one
  always @(negedge clk) begin
    if (rst_n === 1'b1 && redirect_o === 1'b1) begin
      checks++;
      if (q_pc.size() == 0) begin
        errors++;
        $display("FAIL R7 unexpected redirect actual=%h expected=none", redirect_pc_o);
      end else begin
        automatic logic [31:0] epc = q_pc.pop_front();
        automatic logic [1:0]  epr = q_prv.pop_front();
        automatic logic        edm = q_dm.pop_front();
        automatic string       tg  = q_tag.pop_front();
        if (redirect_pc_o !== epc || priv_o !== epr || debug_mode_o !== edm) begin
          errors++;
          $display("FAIL %s redirect actual=%h/%0d/%0b expected=%h/%0d/%0b",
                   tg, redirect_pc_o, priv_o, debug_mode_o, epc, epr, edm);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic csr_rd(input logic [11:0] a, output logic [31:0] d, output logic e);
    csr_en_i = 1'b1; csr_we_i = 1'b0; csr_addr_i = a;
    #1;
    d = csr_rdata_o; e = csr_err_o;
    csr_en_i = 1'b0;
  endtask

  task automatic csr_wr(input logic [11:0] a, input logic [31:0] d);
    csr_en_i = 1'b1; csr_we_i = 1'b1; csr_addr_i = a; csr_wdata_i = d;
    tick();
    csr_en_i = 1'b0; csr_we_i = 1'b0;
  endtask

  task automatic do_dret(input string req, input logic [31:0] pc, input logic [1:0] prv);
    dret_i = 1'b1;
    expect_redirect(req, pc, prv, 1'b0);
    tick();
    dret_i = 1'b0;
    chk({req, " ack"}, {31'd0, resume_ack_o}, 32'd1);
    chk({req, " mode"}, {31'd0, debug_mode_o}, 32'd0);
    chk({req, " halted held"}, {31'd0, halted_o}, 32'd1);
    tick();
    chk({req, " halted drop"}, {31'd0, halted_o}, 32'd0);
    chk({req, " ack pulse"}, {31'd0, resume_ack_o}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic        e;
    rst_n = 1'b0;
    halt_req_i = 0; trig_hit_i = 0; ebreak_i = 0; retire_i = 0; dret_i = 0;
    pc_i = 32'h100; priv_i = 2'd3;
    csr_en_i = 0; csr_we_i = 0; csr_addr_i = '0; csr_wdata_i = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 mode", {31'd0, debug_mode_o}, 32'd0);
    chk("R1 halted", {31'd0, halted_o}, 32'd0);
    chk("R1 redirect", {31'd0, redirect_o}, 32'd0);
    chk("R1 ack", {31'd0, resume_ack_o}, 32'd0);
    chk("R1 trap", {31'd0, ebreak_trap_o}, 32'd0);
    // R10 access outside debug mode
    csr_rd(12'h7B0, d, e);
    chk("R10 err outside", {31'd0, e}, 32'd1);
    chk("R10 rdata outside", d, 32'd0);

    // R2 halt entry
    halt_req_i = 1'b1; pc_i = 32'h100; priv_i = 2'd3;
    expect_redirect("R2", ROM, 2'd3, 1'b1);
    tick();
    halt_req_i = 1'b0;
    chk("R2 mode", {31'd0, debug_mode_o}, 32'd1);
    chk("R2 halted", {31'd0, halted_o}, 32'd1);
    csr_rd(12'h7B0, d, e);
    chk("R2 ctrl", d, 32'h4000_00C3);
    csr_rd(12'h7B1, d, e);
    chk("R2 rpc", d, 32'h100);

    // R10 scratch access in debug mode
    csr_wr(12'h7B2, 32'hA5A5_0001);
    csr_wr(12'h7B3, 32'h5A5A_0002);
    csr_rd(12'h7B2, d, e);
    chk("R10 scr0", d, 32'hA5A5_0001);
    chk("R10 err inside", {31'd0, e}, 32'd0);
    csr_rd(12'h7B3, d, e);
    chk("R10 scr1", d, 32'h5A5A_0002);

    // R9 read-only fields
    csr_wr(12'h7B0, 32'hF000_E03B);
    csr_rd(12'h7B0, d, e);
    chk("R9 ctrl layout", d, 32'h4000_E0C3);

    // R7 events ignored in debug mode
    halt_req_i = 1; trig_hit_i = 1; ebreak_i = 1; retire_i = 1; pc_i = 32'h999;
    #1;
    chk("R7 no trap", {31'd0, ebreak_trap_o}, 32'd0);
    tick();
    halt_req_i = 0; trig_hit_i = 0; ebreak_i = 0; retire_i = 0;
    tick();
    chk("R7 mode", {31'd0, debug_mode_o}, 32'd1);
    csr_rd(12'h7B0, d, e);
    chk("R7 cause kept", d, 32'h4000_E0C3);
    csr_rd(12'h7B1, d, e);
    chk("R7 rpc kept", d, 32'h100);

    // R11 written return PC, R8 exit
    csr_wr(12'h7B1, 32'h200);
    do_dret("R11", 32'h200, 2'd3);

    // R10 write ignored outside debug mode
    csr_en_i = 1; csr_we_i = 1; csr_addr_i = 12'h7B2; csr_wdata_i = 32'h1234;
    #1;
    chk("R10 write err", {31'd0, csr_err_o}, 32'd1);
    tick();
    csr_en_i = 0; csr_we_i = 0;

    // R4 routed ebreak from user mode
    priv_i = 2'd0; pc_i = 32'h300; ebreak_i = 1;
    #1;
    chk("R4 routed no trap", {31'd0, ebreak_trap_o}, 32'd0);
    expect_redirect("R4", ROM, 2'd3, 1'b1);
    tick();
    ebreak_i = 0;
    csr_rd(12'h7B0, d, e);
    chk("R4 ctrl", d, 32'h4000_E040);
    csr_rd(12'h7B1, d, e);
    chk("R4 rpc", d, 32'h300);
    csr_rd(12'h7B2, d, e);
    chk("R10 scr0 kept", d, 32'hA5A5_0001);
    csr_wr(12'h7B0, 32'h0000_8001);
    do_dret("R8", 32'h300, 2'd1);

    // R4 not routed from supervisor mode
    priv_i = 2'd1; pc_i = 32'h310; ebreak_i = 1;
    #1;
    chk("R4 trap", {31'd0, ebreak_trap_o}, 32'd1);
    tick();
    ebreak_i = 0;
    chk("R4 no entry", {31'd0, debug_mode_o}, 32'd0);

    // R5 and R3 trigger beats ebreak and halt
    priv_i = 2'd3; pc_i = 32'h400;
    trig_hit_i = 1; ebreak_i = 1; halt_req_i = 1;
    expect_redirect("R5", ROM, 2'd3, 1'b1);
    tick();
    trig_hit_i = 0; ebreak_i = 0; halt_req_i = 0;
    csr_rd(12'h7B0, d, e);
    chk("R5 R3 trigger cause", d, 32'h4000_8083);
    csr_rd(12'h7B1, d, e);
    chk("R3 rpc", d, 32'h400);

    // R6 single step
    csr_wr(12'h7B0, 32'h0000_8007);
    do_dret("R6 exit", 32'h400, 2'd3);
    tick();
    chk("R6 waits for retire", {31'd0, debug_mode_o}, 32'd0);
    retire_i = 1; pc_i = 32'h400;
    expect_redirect("R6", ROM, 2'd3, 1'b1);
    tick();
    retire_i = 0; pc_i = 32'h404;
    chk("R6 not yet", {31'd0, debug_mode_o}, 32'd0);
    tick();
    chk("R6 entered", {31'd0, debug_mode_o}, 32'd1);
    csr_rd(12'h7B0, d, e);
    chk("R6 ctrl", d, 32'h4000_8107);
    csr_rd(12'h7B1, d, e);
    chk("R6 rpc", d, 32'h404);

    // R5 halt beats pending step
    do_dret("R6 exit2", 32'h404, 2'd3);
    retire_i = 1; pc_i = 32'h404;
    expect_redirect("R5 halt/step", ROM, 2'd3, 1'b1);
    tick();
    retire_i = 0; halt_req_i = 1; pc_i = 32'h408;
    tick();
    halt_req_i = 0;
    chk("R5 mode", {31'd0, debug_mode_o}, 32'd1);
    csr_rd(12'h7B0, d, e);
    chk("R5 halt over step", d, 32'h4000_80C7);
    csr_rd(12'h7B1, d, e);
    chk("R5 rpc", d, 32'h408);

    // R5 ebreak beats halt
    csr_wr(12'h7B0, 32'h0000_8003);
    do_dret("R5 exit", 32'h408, 2'd3);
    pc_i = 32'h500; ebreak_i = 1; halt_req_i = 1;
    expect_redirect("R5 eb/halt", ROM, 2'd3, 1'b1);
    tick();
    ebreak_i = 0; halt_req_i = 0;
    csr_rd(12'h7B0, d, e);
    chk("R5 ebreak over halt", d, 32'h4000_8043);
    do_dret("R8 final", 32'h500, 2'd3);

    tick();
    chk("R8 all redirects seen", q_pc.size(), 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule